// File: doc/BRIEF.md
# TDM Serial Receiver with Slot Mask

This block receives a time-division multiplexed serial stream. It runs directly on the serial bit clock. On each rising edge it samples one data bit, most significant bit first. A frame-sync pulse marks bit 0 of slot 0, and the pulse is sampled on the same edge as that bit. Each frame holds a programmable number of slots, and each slot holds a programmable number of bits. The block outputs each captured slot word on a single-cycle valid strobe, together with the word's slot index.

The block has two capture policies. In normal mode only the first slot of every frame is captured, and the remaining slots only make the frame longer. In network mode each slot is checked against a 32-bit mask, one bit per slot. A slot is captured when its mask bit is 0 and skipped when its mask bit is 1. The mask is copied into a shadow register at every slot boundary, so a mask change made in the middle of a slot never affects that slot.

The control logic is a four-state machine:
- `ST_IDLE`: the receiver is disabled.
- `ST_HUNT`: the receiver is enabled and waiting for a frame sync.
- `ST_TAKE`: the current slot is being captured.
- `ST_SKIP`: the current slot is being counted but not captured.

Transitions:
- Enable low sends the machine to `ST_IDLE` from any state.
- From `ST_IDLE`, enable high with no sync goes to `ST_HUNT`.
- From any state, enable high with a sync goes to `ST_TAKE` or `ST_SKIP`, chosen by the decision for slot 0.
- At the final bit of a slot that is not the last slot, the machine enters `ST_TAKE` or `ST_SKIP` for the next slot.
- At the final bit of the last slot, the machine returns to `ST_HUNT`.

Top module: `tdm_rx_slot_mask`

## Requirements
- R1: After reset, `word_valid` is 0, `word_data` is 0 and `word_slot` is 0.
- R2: Bits are taken MSB first. The effective word length is `word_len` clamped to the range 8..24. Each word is right-justified in `word_data` with its upper bits zero.
- R3: A frame has `slot_count` slots, clamped to the range 1..32, where a setting of 0 counts as 1. After the last slot the receiver ignores the line until the next frame sync. `word_slot` reports the slot index, counting from 0.
- R4: When `net_mode` is 0, only slot 0 of each frame is output.
- R5: When `net_mode` is 1, slot s is output exactly when bit s of the mask in force for that slot is 0.
- R6: The mask in force for slot 0 is the `mask_in` value sampled on the frame-sync edge. For slot s>0 it is the value sampled on the edge that takes the final bit of slot s-1. Later changes do not affect the slot already in progress.
- R7: `word_valid` is high for exactly one cycle, namely the cycle after the edge that samples a word's final bit.
- R8: A frame sync that arrives before the frame has ended restarts the frame at slot 0 and drops the partial word, which is never output.
- R9: While `rx_en` is 0, no word is output and the machine stays in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| net_mode | input | 1 | 0: normal mode (slot 0 only); 1: network mode (masked slots) |
| word_len | input | 5 | Bits per slot, clamped to 8..24 |
| slot_count | input | 6 | Slots per frame, clamped to 1..32 |
| mask_in | input | 32 | Per-slot skip mask; bit s = 1 skips slot s |
| frame_sync | input | 1 | High during bit 0 of slot 0 |
| ser_in | input | 1 | Serial data line |
| word_valid | output | 1 | One-cycle strobe for a captured word |
| word_data | output | 24 | Captured word, right-justified |
| word_slot | output | 5 | Slot index of the captured word |

## Verification
The hardest case to reach from the ports is a mask change that lands exactly on a slot boundary. The outcome differs depending on whether the change falls on the final bit of one slot or on the first bit of the next. The stimulus task therefore switches `mask_in` at a chosen absolute bit position within the frame. One scenario runs three such positions: the middle of slot 1, the last bit of slot 1 and the first bit of slot 2. A second hard case is a sync arriving in the middle of a word. It is produced by cutting one frame short after a few bits of slot 1 and starting the next frame on the very next edge.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_TAKE = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_e;

endpackage

// File: rtl/tdm_rx_slot_counter.sv
module tdm_rx_slot_counter #(
    parameter int BIT_W  = 5,
    parameter int SLOT_W = 5,
    parameter int WL_W   = 5,
    parameter int SC_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [WL_W-1:0]   wl_eff,
    input  logic [SC_W-1:0]   sc_eff,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              last_bit,
    output logic              last_slot
);

    // bit_idx is the index, within its slot, of the bit sampled at the coming edge
    assign last_bit  = (int'(bit_idx)  == int'(wl_eff) - 1);
    assign last_slot = (int'(slot_idx) == int'(sc_eff) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (restart) begin
            // the sync edge itself takes bit 0 of slot 0
            bit_idx  <= BIT_W'(1);
            slot_idx <= '0;
        end else if (step) begin
            if (last_bit) begin
                bit_idx  <= '0;
                slot_idx <= slot_idx + SLOT_W'(1);
            end else begin
                bit_idx  <= bit_idx + BIT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdm_rx_slot_gate.sv
module tdm_rx_slot_gate #(
    parameter int MAX_SLOTS = 32,
    parameter int SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 net_mode,
    input  logic [MAX_SLOTS-1:0] mask_in,
    input  logic [SLOT_W-1:0]    next_slot,
    output logic                 accept_next,
    output logic [MAX_SLOTS-1:0] shadow_q,
    output logic                 mode_q
);

    // capture decision for the slot about to start, from the live inputs
    always_comb begin
        if (net_mode) begin
            accept_next = ~mask_in[next_slot];
        end else begin
            accept_next = (next_slot == '0);
        end
    end

    // copy held for the running slot, refreshed only at a slot boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            mode_q   <= 1'b0;
        end else if (load) begin
            shadow_q <= mask_in;
            mode_q   <= net_mode;
        end
    end

endmodule

// File: rtl/tdm_rx_shifter.sv
module tdm_rx_shifter #(
    parameter int DATA_W = 24,
    parameter int WL_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic [WL_W-1:0]   wl_eff,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-2:0] sh_q;
    logic [DATA_W-1:0] assembled;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] one_w;

    assign one_w     = DATA_W'(1);
    assign assembled = {sh_q, ser_in};
    // low wl_eff bits set; wraps to all ones when wl_eff equals DATA_W
    assign keep_mask = (one_w << wl_eff) - one_w;
    assign word      = assembled & keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= assembled[DATA_W-2:0];
        end
    end

endmodule

// File: rtl/tdm_rx_slot_mask.sv
module tdm_rx_slot_mask #(
    parameter int DATA_W    = 24,
    parameter int MIN_WL    = 8,
    parameter int MAX_SLOTS = 32
) (
    input  logic                             bclk,
    input  logic                             rst_n,
    input  logic                             rx_en,
    input  logic                             net_mode,
    input  logic [$clog2(DATA_W+1)-1:0]      word_len,
    input  logic [$clog2(MAX_SLOTS+1)-1:0]   slot_count,
    input  logic [MAX_SLOTS-1:0]             mask_in,
    input  logic                             frame_sync,
    input  logic                             ser_in,
    output logic                             word_valid,
    output logic [DATA_W-1:0]                word_data,
    output logic [$clog2(MAX_SLOTS)-1:0]     word_slot
);
    import tdm_rx_pkg::*;

    localparam int WL_W   = $clog2(DATA_W + 1);
    localparam int SC_W   = $clog2(MAX_SLOTS + 1);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int SLOT_W = $clog2(MAX_SLOTS);

    rx_state_e           state_q;
    rx_state_e           state_d;
    logic [WL_W-1:0]     wl_eff;
    logic [SC_W-1:0]     sc_eff;
    logic [BIT_W-1:0]    bit_idx;
    logic [SLOT_W-1:0]   slot_idx;
    logic [SLOT_W-1:0]   next_slot;
    logic                last_bit;
    logic                last_slot;
    logic                active;
    logic                restart;
    logic                step;
    logic                load_slot;
    logic                accept_next;
    logic [MAX_SLOTS-1:0] shadow_q;
    logic                mode_q;
    logic [DATA_W-1:0]   word;
    logic                emit;

    // clamp the configuration into its legal range
    always_comb begin
        if (word_len < WL_W'(MIN_WL)) begin
            wl_eff = WL_W'(MIN_WL);
        end else if (word_len > WL_W'(DATA_W)) begin
            wl_eff = WL_W'(DATA_W);
        end else begin
            wl_eff = word_len;
        end
        if (slot_count == '0) begin
            sc_eff = SC_W'(1);
        end else if (slot_count > SC_W'(MAX_SLOTS)) begin
            sc_eff = SC_W'(MAX_SLOTS);
        end else begin
            sc_eff = slot_count;
        end
    end

    assign active    = (state_q == ST_TAKE) || (state_q == ST_SKIP);
    assign restart   = rx_en && frame_sync;
    assign step      = rx_en && active && !frame_sync;
    assign load_slot = restart || (step && last_bit && !last_slot);
    assign next_slot = restart ? '0 : (slot_idx + SLOT_W'(1));
    assign emit      = step && (state_q == ST_TAKE) && last_bit;

    tdm_rx_slot_counter #(
        .BIT_W  (BIT_W),
        .SLOT_W (SLOT_W),
        .WL_W   (WL_W),
        .SC_W   (SC_W)
    ) counter_i (
        .clk       (bclk),
        .rst_n     (rst_n),
        .restart   (restart),
        .step      (step),
        .wl_eff    (wl_eff),
        .sc_eff    (sc_eff),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .last_bit  (last_bit),
        .last_slot (last_slot)
    );

    tdm_rx_slot_gate #(
        .MAX_SLOTS (MAX_SLOTS),
        .SLOT_W    (SLOT_W)
    ) gate_i (
        .clk         (bclk),
        .rst_n       (rst_n),
        .load        (load_slot),
        .net_mode    (net_mode),
        .mask_in     (mask_in),
        .next_slot   (next_slot),
        .accept_next (accept_next),
        .shadow_q    (shadow_q),
        .mode_q      (mode_q)
    );

    tdm_rx_shifter #(
        .DATA_W (DATA_W),
        .WL_W   (WL_W)
    ) shifter_i (
        .clk      (bclk),
        .rst_n    (rst_n),
        .shift_en (rx_en),
        .ser_in   (ser_in),
        .wl_eff   (wl_eff),
        .word     (word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = ST_IDLE;
        end else if (frame_sync) begin
            state_d = accept_next ? ST_TAKE : ST_SKIP;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_HUNT;
                ST_HUNT: state_d = ST_HUNT;
                ST_TAKE,
                ST_SKIP: begin
                    if (last_bit) begin
                        if (last_slot) begin
                            state_d = ST_HUNT;
                        end else begin
                            state_d = accept_next ? ST_TAKE : ST_SKIP;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
            word_slot  <= '0;
        end else begin
            word_valid <= emit;
            if (emit) begin
                word_data <= word;
                word_slot <= slot_idx;
            end
        end
    end

endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker #(
    parameter int MAX_SLOTS = 32,
    parameter int SLOT_W    = 5,
    parameter int BIT_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 frame_sync,
    input logic                 word_valid,
    input tdm_rx_pkg::rx_state_e state,
    input logic [SLOT_W-1:0]    slot_idx,
    input logic [BIT_W-1:0]     bit_idx,
    input logic [MAX_SLOTS-1:0] shadow,
    input logic                 mode,
    input logic                 load
);
    import tdm_rx_pkg::*;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R7

    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(rx_en)); // R9

    AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE)); // R9

    AST_NORMAL_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAKE && !mode) |-> (slot_idx == '0)); // R4

    AST_MASK_HONORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAKE && mode) |-> !shadow[slot_idx]); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow)); // R6

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && frame_sync) |=> (slot_idx == '0 && bit_idx == BIT_W'(1))); // R8

endmodule

bind tdm_rx_slot_mask tdm_rx_checker #(
    .MAX_SLOTS (MAX_SLOTS),
    .SLOT_W    ($clog2(MAX_SLOTS)),
    .BIT_W     ($clog2(DATA_W))
) chk_i (
    .clk        (bclk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .frame_sync (frame_sync),
    .word_valid (word_valid),
    .state      (state_q),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .shadow     (shadow_q),
    .mode       (mode_q),
    .load       (load_slot)
);

// File: tb/tdm_rx_slot_mask_tb_top.sv
module tdm_rx_slot_mask_tb_top;

    localparam int NO_CHG = 1 << 30;

    logic        bclk = 1'b0;
    logic        rst_n;
    logic        rx_en;
    logic        net_mode;
    logic [4:0]  word_len;
    logic [5:0]  slot_count;
    logic [31:0] mask_in;
    logic        frame_sync;
    logic        ser_in;
    logic        word_valid;
    logic [23:0] word_data;
    logic [4:0]  word_slot;

    int checks = 0;
    int errors = 0;

    logic [23:0] cap_d [0:63];
    logic [4:0]  cap_s [0:63];
    int          cap_n = 0;
    logic [23:0] exp_d [0:63];
    logic [4:0]  exp_s [0:63];
    int          exp_n = 0;

    always #5 bclk = ~bclk;

    tdm_rx_slot_mask dut_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .net_mode   (net_mode),
        .word_len   (word_len),
        .slot_count (slot_count),
        .mask_in    (mask_in),
        .frame_sync (frame_sync),
        .ser_in     (ser_in),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_slot  (word_slot)
    );

    // capture every valid cycle; a stretched strobe shows up as an extra word
    always @(negedge bclk) begin
        if (rst_n && word_valid && cap_n < 64) begin
            cap_d[cap_n] = word_data;
            cap_s[cap_n] = word_slot;
            cap_n = cap_n + 1;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge bclk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pat(input int base, input int s, input int wl);
        logic [23:0] v;
        logic [23:0] m;
        v = 24'(base * 40503 + s * 2654435 + 17);
        m = (24'h1 << wl) - 24'h1;
        return v & m;
    endfunction

    task automatic clear_all();
        cap_n = 0;
        exp_n = 0;
    endtask

    // drives nbits of a frame starting with a sync; mask switches to mb from bit chg on
    task automatic play(input logic en, input logic net, input int wl_set, input int sc_set,
                        input int wl_eff, input int nbits, input logic [31:0] ma,
                        input logic [31:0] mb, input int chg, input int base, input int tail);
        for (int n = 0; n < nbits; n++) begin
            logic [23:0] w;
            rx_en      = en;
            net_mode   = net;
            word_len   = 5'(wl_set);
            slot_count = 6'(sc_set);
            frame_sync = (n == 0);
            mask_in    = (n >= chg) ? mb : ma;
            w          = pat(base, n / wl_eff, wl_eff);
            ser_in     = w[wl_eff - 1 - (n % wl_eff)];
            @(negedge bclk);
        end
        frame_sync = 1'b0;
        ser_in     = 1'b0;
        repeat (tail) @(negedge bclk);
    endtask

    // expected words: slot s uses the mask seen at its boundary bit (R6)
    task automatic expect_frame(input logic net, input int wl_eff, input int nslots,
                                input logic [31:0] ma, input logic [31:0] mb,
                                input int chg, input int base);
        for (int s = 0; s < nslots; s++) begin
            int          pos;
            logic [31:0] m;
            logic        acc;
            pos = (s == 0) ? 0 : s * wl_eff - 1;
            m   = (pos >= chg) ? mb : ma;
            acc = net ? !m[s] : (s == 0);
            if (acc) begin
                exp_d[exp_n] = pat(base, s, wl_eff);
                exp_s[exp_n] = 5'(s);
                exp_n++;
            end
        end
    endtask

    task automatic compare(input string req);
        chk({req, " word count"}, 32'(cap_n), 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            if (i < cap_n) begin
                chk({req, " data"}, 32'(cap_d[i]), 32'(exp_d[i]));
                chk({req, " slot"}, 32'(cap_s[i]), 32'(exp_s[i]));
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(word_valid), 32'd0);
        chk("R1 data", 32'(word_data), 32'd0);
        chk("R1 slot", 32'(word_slot), 32'd0);
    endtask

    task automatic t_normal();
        // R4 R7: two back-to-back frames, 16-bit words, 4 slots, only slot 0 kept
        clear_all();
        play(1'b1, 1'b0, 16, 4, 16, 64, 32'h0, 32'h0, NO_CHG, 11, 0);
        play(1'b1, 1'b0, 16, 4, 16, 64, 32'h0, 32'h0, NO_CHG, 12, 3);
        expect_frame(1'b0, 16, 4, 32'h0, 32'h0, NO_CHG, 11);
        expect_frame(1'b0, 16, 4, 32'h0, 32'h0, NO_CHG, 12);
        compare("R4");
    endtask

    task automatic t_network_all();
        clear_all();
        play(1'b1, 1'b1, 8, 8, 8, 64, 32'h0, 32'h0, NO_CHG, 21, 3);
        expect_frame(1'b1, 8, 8, 32'h0, 32'h0, NO_CHG, 21);
        compare("R5 all open");
    endtask

    task automatic t_network_mask();
        // R5 R2: 24-bit words, mask 0xA5 skips slots 0,2,5,7
        clear_all();
        play(1'b1, 1'b1, 24, 8, 24, 192, 32'hA5, 32'hA5, NO_CHG, 31, 3);
        expect_frame(1'b1, 24, 8, 32'hA5, 32'hA5, NO_CHG, 31);
        compare("R5 R2 mask A5");
    endtask

    task automatic t_mask_change();
        // R6: switch to mask 0x3C at mid slot 1, last bit of slot 1, first bit of slot 2
        clear_all();
        play(1'b1, 1'b1, 12, 6, 12, 72, 32'h0, 32'h3C, 17, 41, 3);
        expect_frame(1'b1, 12, 6, 32'h0, 32'h3C, 17, 41);
        compare("R6 mid slot");
        clear_all();
        play(1'b1, 1'b1, 12, 6, 12, 72, 32'h0, 32'h3C, 23, 42, 3);
        expect_frame(1'b1, 12, 6, 32'h0, 32'h3C, 23, 42);
        compare("R6 boundary bit");
        clear_all();
        play(1'b1, 1'b1, 12, 6, 12, 72, 32'h0, 32'h3C, 24, 43, 3);
        expect_frame(1'b1, 12, 6, 32'h0, 32'h3C, 24, 43);
        compare("R6 after boundary");
    endtask

    task automatic t_early_sync();
        // R8: sync after 4 bits of slot 1; partial word dropped
        clear_all();
        play(1'b1, 1'b1, 8, 4, 8, 12, 32'h0, 32'h0, NO_CHG, 51, 0);
        play(1'b1, 1'b1, 8, 4, 8, 32, 32'h0, 32'h0, NO_CHG, 52, 3);
        expect_frame(1'b1, 8, 1, 32'h0, 32'h0, NO_CHG, 51);
        expect_frame(1'b1, 8, 4, 32'h0, 32'h0, NO_CHG, 52);
        compare("R8");
    endtask

    task automatic t_disabled();
        clear_all();
        play(1'b0, 1'b1, 8, 4, 8, 32, 32'h0, 32'h0, NO_CHG, 61, 3);
        compare("R9 disabled");
    endtask

    task automatic t_clamps();
        // R2: word_len 30 acts as 24, word_len 3 acts as 8
        clear_all();
        play(1'b1, 1'b1, 30, 2, 24, 48, 32'h0, 32'h0, NO_CHG, 71, 3);
        expect_frame(1'b1, 24, 2, 32'h0, 32'h0, NO_CHG, 71);
        compare("R2 clamp high");
        clear_all();
        play(1'b1, 1'b1, 3, 2, 8, 16, 32'h0, 32'h0, NO_CHG, 72, 3);
        expect_frame(1'b1, 8, 2, 32'h0, 32'h0, NO_CHG, 72);
        compare("R2 clamp low");
        // R3: slot_count 0 acts as 1; slot-1 bits without sync are ignored
        clear_all();
        play(1'b1, 1'b1, 8, 0, 8, 16, 32'h0, 32'h0, NO_CHG, 73, 3);
        expect_frame(1'b1, 8, 1, 32'h0, 32'h0, NO_CHG, 73);
        compare("R3 one slot");
    endtask

    task automatic t_slot31();
        // R3 R5: 32 slots, only slots 0 and 31 open
        clear_all();
        play(1'b1, 1'b1, 8, 32, 8, 256, 32'h7FFF_FFFE, 32'h0, NO_CHG, 81, 3);
        expect_frame(1'b1, 8, 32, 32'h7FFF_FFFE, 32'h0, NO_CHG, 81);
        compare("R3 slot 31");
    endtask

    initial begin
        rst_n      = 1'b0;
        rx_en      = 1'b0;
        net_mode   = 1'b0;
        word_len   = 5'd8;
        slot_count = 6'd1;
        mask_in    = 32'h0;
        frame_sync = 1'b0;
        ser_in     = 1'b0;
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;
        @(negedge bclk);
        t_reset();
        t_normal();
        t_network_all();
        t_network_mask();
        t_mask_change();
        t_early_sync();
        t_disabled();
        t_clamps();
        t_slot31();
        summary();
        $finish;
    end

endmodule